// File: doc/BRIEF.md
# GPIO Interrupt Style Detector

This block watches sixteen general-purpose input pins and turns selected pin activity into interrupt requests. Each pin has its own three-bit trigger style. The style selects one of five detection modes: level high, level low, rising edge, falling edge, or either edge. The remaining codes switch detection off. Pin inputs are first brought into the clock domain by a two-flop synchronizer. The detector then compares the current synchronized value with the sample from the previous cycle.

A detection sets a sticky pending bit for its pin. Software clears a pending bit by writing a one to it. A level-style pending bit cannot stay cleared while its level is still present, because the detector sets it again straight away. Each pending bit drives its own interrupt output toward a downstream interrupt controller, and one extra output is the OR of all sixteen bits. When software changes the style of a pin, that pin's pending bit is cleared, so a detection made under the old style is discarded.

Software reaches the block through a word-wide register port with three registers: two style words, one for each bank of eight pins, and the pending-status word.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous active-low reset, all style fields and pending bits are zero, `irq_pin` and `irq_any` are low, and every register reads zero.
- R2: Style code 0 (level high) sets the pin's pending bit in every cycle in which the synchronized input is 1.
- R3: Style code 1 (level low) sets the pin's pending bit in every cycle in which the synchronized input is 0.
- R4: Style code 2 (rising) sets the pending bit once for each 0-to-1 transition. A 1-to-0 transition has no effect.
- R5: Style code 3 (falling) sets the pending bit once for each 1-to-0 transition. A 0-to-1 transition has no effect.
- R6: Style code 4 (either edge) sets the pending bit on every transition in either direction.
- R7: Style codes 5, 6 and 7 never set the pending bit.
- R8: Register address 0 holds the styles of pins 0 to 7 and address 1 those of pins 8 to 15. Pin p uses bits [3*(p mod 8)+2 : 3*(p mod 8)] of its bank word. Both words read back as written. Address 3 reads zero, and writes to it change nothing.
- R9: Address 2 holds the pending bits in bits [15:0]. Writing a 1 at bit n clears pin n's bit. A 0 leaves the bit unchanged. Pending bits are sticky.
- R10: A level-style pending bit reads 1 again in the cycle after a clear if its level is still present.
- R11: When an edge detection and a write-1-to-clear for the same pin fall in the same cycle, the pending bit ends up set.
- R12: A write to a style word clears the pending bit of every pin whose field value changes and discards that pin's detection in that cycle. Pins whose field is rewritten with the same value keep their pending bit.
- R13: `irq_pin[n]` equals pending bit n, and `irq_any` is the OR of all pending bits.
- R14: A pin change driven before clock edge k appears in the pending bit after edge k+2. After reset, edge styles do not detect until the sample history holds three real samples, so a pin held high through reset does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 16 | Asynchronous pin inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0, 1 style banks; 2 pending status |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for `reg_addr`, combinational |
| irq_pin | output | 16 | Per-pin interrupt request, equal to the pending bits |
| irq_any | output | 1 | OR of all pending bits |

## Verification
Two events can hit the same pending bit in one clock: a detection and a register write. The write is either a write-1-to-clear or a style change. The bench times an either-edge transition so that its one-cycle detection lands exactly on the clock that carries a clear for that pin, and expects the bit to read 1 afterwards. It also rewrites a pin's style while its level condition is active, and expects that bit to read 0 with its neighbours untouched. A cycle-accurate bench model, fed with random pin toggles and random register writes, keeps comparing every output and every readback so that other coincidences are judged as well.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants for the GPIO interrupt style detector.
// Holds the style-code encoding, its field width and the detection rule,
// so that the RTL uses one definition of each code.
package gpio_irq_pkg;

    localparam int STYLE_W = 3;

    localparam logic [STYLE_W-1:0] STY_LVL_HIGH = 3'd0;
    localparam logic [STYLE_W-1:0] STY_LVL_LOW  = 3'd1;
    localparam logic [STYLE_W-1:0] STY_RISE     = 3'd2;
    localparam logic [STYLE_W-1:0] STY_FALL     = 3'd3;
    localparam logic [STYLE_W-1:0] STY_ANY_EDGE = 3'd4;

    // Detection rule for one pin: level styles need a valid current sample,
    // edge styles need a valid previous sample as well.
    function automatic logic style_hit(
        input logic [STYLE_W-1:0] code,
        input logic               cur,
        input logic               prv,
        input logic               lvl_ok,
        input logic               edge_ok
    );
        case (code)
            STY_LVL_HIGH: return cur & lvl_ok;
            STY_LVL_LOW:  return ~cur & lvl_ok;
            STY_RISE:     return cur & ~prv & edge_ok;
            STY_FALL:     return ~cur & prv & edge_ok;
            STY_ANY_EDGE: return (cur ^ prv) & edge_ok;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
// Module: gpio_pin_sync
// Brings asynchronous pins into the clock domain with two flops and keeps
// one more sample as edge history. A warm-up shift register reports when
// the synchronized value and the history hold real samples.
// Assumes: pins are slow compared with clk; reset is synchronous, active low.
module gpio_pin_sync #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] cur_o,
    output logic [NUM_PINS-1:0] prev_o,
    output logic                lvl_ok_o,
    output logic                edge_ok_o
);

    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] hist_q;
    logic [2:0]          warm_q;

    // Synchronizer chain plus history; reset discards stale samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            hist_q <= '0;
            warm_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            hist_q <= sync_q;
            warm_q <= {warm_q[1:0], 1'b1};
        end
    end

    assign cur_o     = sync_q;
    assign prev_o    = hist_q;
    assign lvl_ok_o  = warm_q[1];
    assign edge_ok_o = warm_q[2];

endmodule

// File: rtl/gpio_style_regs.sv
// Module: gpio_style_regs
// Holds the per-pin style fields as one word per bank of pins, and flags
// the pins whose field value changes on a write.
// Assumes: bank b sits at register address b; write data is one bank wide.
module gpio_style_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS      = 16,
    parameter int PINS_PER_BANK = 8,
    parameter int ADDR_W        = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [PINS_PER_BANK*STYLE_W-1:0] wdata_i,
    output logic [NUM_PINS*STYLE_W-1:0]   style_o,
    output logic [NUM_PINS-1:0]           chg_o
);

    localparam int NUM_BANKS = NUM_PINS / PINS_PER_BANK;
    localparam int BANK_W    = PINS_PER_BANK * STYLE_W;

    logic [NUM_PINS*STYLE_W-1:0] style_q;
    logic [NUM_BANKS-1:0]        bank_sel;

    genvar gb, gp;
    generate
        for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
            // Address decode for this bank.
            assign bank_sel[gb] = wr_i && (addr_i == ADDR_W'(gb));

            // R8: a selected bank loads the written word.
            p_cfg_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
                bank_sel[gb] |=> (style_q[gb*BANK_W +: BANK_W] == $past(wdata_i)));
        end

        for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
            localparam int BK  = gp / PINS_PER_BANK;
            localparam int OFS = (gp % PINS_PER_BANK) * STYLE_W;
            // Field-change flag for this pin.
            assign chg_o[gp] = bank_sel[BK] &&
                (wdata_i[OFS +: STYLE_W] != style_q[gp*STYLE_W +: STYLE_W]);
        end
    endgenerate

    // Style storage, one bank word per address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            style_q <= '0;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_sel[b]) style_q[b*BANK_W +: BANK_W] <= wdata_i;
            end
        end
    end

    assign style_o = style_q;

endmodule

// File: rtl/gpio_style_detect.sv
// Module: gpio_style_detect
// Applies each pin's style code to its synchronized value and history and
// gives a one-cycle detection pulse (held for level styles).
// Assumes: clk and rst_n are used only by the embedded checks.
module gpio_style_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS*STYLE_W-1:0] style_i,
    input  logic [NUM_PINS-1:0]         cur_i,
    input  logic [NUM_PINS-1:0]         prev_i,
    input  logic                        lvl_ok_i,
    input  logic                        edge_ok_i,
    output logic [NUM_PINS-1:0]         evt_o
);

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PINS; gp++) begin : g_det
            // Per-pin detection by style code.
            assign evt_o[gp] = style_hit(style_i[gp*STYLE_W +: STYLE_W],
                                         cur_i[gp], prev_i[gp], lvl_ok_i, edge_ok_i);

            // R7: the codes above the last defined style never detect.
            p_off_codes_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (style_i[gp*STYLE_W +: STYLE_W] > STY_ANY_EDGE) |-> !evt_o[gp]);

            // R14: no edge detection before the history holds real samples.
            p_edge_warmup_r14: assert property (@(posedge clk) disable iff (!rst_n)
                (!edge_ok_i && (style_i[gp*STYLE_W +: STYLE_W] >= STY_RISE))
                    |-> !evt_o[gp]);
        end
    endgenerate

endmodule

// File: rtl/gpio_pend_status.sv
// Module: gpio_pend_status
// Sticky pending bits: set by detections, cleared by write-1-to-clear and
// by a style change. A detection beats a software clear in the same cycle;
// a style change discards that cycle's detection.
// Assumes: all inputs are single-cycle masks from the same clock.
module gpio_pend_status #(
    parameter int NUM_PINS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] evt_i,
    input  logic [NUM_PINS-1:0] w1c_i,
    input  logic [NUM_PINS-1:0] chg_i,
    output logic [NUM_PINS-1:0] pend_o
);

    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] set_m;
    logic [NUM_PINS-1:0] clr_m;

    // Set and clear masks for this cycle.
    always_comb begin
        set_m = evt_i & ~chg_i;
        clr_m = w1c_i | chg_i;
    end

    // Pending-bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_m) | set_m;
    end

    assign pend_o = pend_q;

    // R9: a software clear without a detection leaves the bit at zero.
    p_w1c_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(w1c_i & ~evt_i)) == '0));

    // R9: bits untouched by any clear or detection keep their value.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pend_q ^ $past(pend_q)) & ~$past(w1c_i | chg_i | evt_i)) == '0));

    // R11: a detection outside a style change always leaves the bit set.
    p_set_beats_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(evt_i & ~chg_i)) == $past(evt_i & ~chg_i)));

endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect (top)
// GPIO interrupt style detector: synchronizer, per-pin style detection,
// sticky pending bits, register port and interrupt outputs.
// Assumes: bank words live at addresses 0..NUM_BANKS-1, status at NUM_BANKS;
// a bank word is at least NUM_PINS bits wide.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS      = 16,
    parameter int PINS_PER_BANK = 8,
    parameter int ADDR_W        = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_PINS-1:0]              pin_in,
    input  logic                             reg_wr,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [PINS_PER_BANK*STYLE_W-1:0] reg_wdata,
    output logic [PINS_PER_BANK*STYLE_W-1:0] reg_rdata,
    output logic [NUM_PINS-1:0]              irq_pin,
    output logic                             irq_any
);

    localparam int NUM_BANKS   = NUM_PINS / PINS_PER_BANK;
    localparam int REG_W       = PINS_PER_BANK * STYLE_W;
    localparam int STATUS_ADDR = NUM_BANKS;

    logic [NUM_PINS-1:0]         cur;
    logic [NUM_PINS-1:0]         prv;
    logic                        lvl_ok;
    logic                        edge_ok;
    logic [NUM_PINS*STYLE_W-1:0] style;
    logic [NUM_PINS-1:0]         chg;
    logic [NUM_PINS-1:0]         evt;
    logic [NUM_PINS-1:0]         w1c;
    logic [NUM_PINS-1:0]         pend;

    gpio_pin_sync #(.NUM_PINS(NUM_PINS)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_in),
        .cur_o     (cur),
        .prev_o    (prv),
        .lvl_ok_o  (lvl_ok),
        .edge_ok_o (edge_ok)
    );

    gpio_style_regs #(
        .NUM_PINS      (NUM_PINS),
        .PINS_PER_BANK (PINS_PER_BANK),
        .ADDR_W        (ADDR_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .style_o (style),
        .chg_o   (chg)
    );

    gpio_style_detect #(.NUM_PINS(NUM_PINS)) i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .style_i   (style),
        .cur_i     (cur),
        .prev_i    (prv),
        .lvl_ok_i  (lvl_ok),
        .edge_ok_i (edge_ok),
        .evt_o     (evt)
    );

    // Write-1-to-clear mask from a status write.
    always_comb begin
        w1c = '0;
        if (reg_wr && (reg_addr == ADDR_W'(STATUS_ADDR))) w1c = reg_wdata[NUM_PINS-1:0];
    end

    gpio_pend_status #(.NUM_PINS(NUM_PINS)) i_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt),
        .w1c_i  (w1c),
        .chg_i  (chg),
        .pend_o (pend)
    );

    // Read multiplexer over bank words and status; others read zero.
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == ADDR_W'(b)) reg_rdata = style[b*REG_W +: REG_W];
        end
        if (reg_addr == ADDR_W'(STATUS_ADDR)) reg_rdata[NUM_PINS-1:0] = pend;
    end

    assign irq_pin = pend;
    assign irq_any = |pend;

    // R12: a pin whose style changed shows no request in the next cycle.
    p_style_chg_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |=> ((irq_pin & $past(chg)) == '0));

endmodule

// File: tb/test_gpio_irq_detect.sv
// Bench for gpio_irq_detect: directed corner cases, then random pin and
// register traffic compared against a cycle-accurate bench model.
module test_gpio_irq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin_in = '0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic [15:0] irq_pin;
    logic        irq_any;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_detect i_gpio_irq_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_pin   (irq_pin),
        .irq_any   (irq_any)
    );

    // Bench model state, built from the requirements.
    logic [15:0] m_s1, m_s2, m_prev, m_st;
    logic [2:0]  m_warm;
    logic [2:0]  m_sty [16];

    function automatic logic exp_hit(logic [2:0] code, logic cur, logic prv,
                                     logic lok, logic eok);
        case (code)
            3'd0:    return cur & lok;              // R2
            3'd1:    return ~cur & lok;             // R3
            3'd2:    return cur & ~prv & eok;       // R4
            3'd3:    return ~cur & prv & eok;       // R5
            3'd4:    return (cur ^ prv) & eok;      // R6
            default: return 1'b0;                   // R7
        endcase
    endfunction

    function automatic logic [23:0] exp_rd(logic [1:0] a);
        logic [23:0] v;
        v = '0;
        if (a == 2'd2) v[15:0] = m_st;
        else if (a != 2'd3) begin
            for (int k = 0; k < 8; k++) v[k*3 +: 3] = m_sty[a*8 + k];
        end
        return v;
    endfunction

    always @(posedge clk) begin
        logic [15:0] setv, clrv;
        logic [2:0]  nf;
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_st <= '0; m_warm <= '0;
            for (int p = 0; p < 16; p++) m_sty[p] <= '0;
        end else begin
            setv = '0;
            clrv = '0;
            if (reg_wr && reg_addr == 2'd2) clrv = reg_wdata[15:0];
            for (int p = 0; p < 16; p++) begin
                nf = m_sty[p];
                if (reg_wr && reg_addr == 2'(p / 8)) nf = reg_wdata[(p % 8)*3 +: 3];
                if (nf != m_sty[p]) clrv[p] = 1'b1;
                else setv[p] = exp_hit(m_sty[p], m_s2[p], m_prev[p], m_warm[1], m_warm[2]);
                m_sty[p] <= nf;
            end
            m_st   <= (m_st & ~clrv) | setv;
            m_s1   <= pin_in;
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_warm <= {m_warm[1:0], 1'b1};
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [23:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [23:0] bank0(logic [2:0] c0, logic [2:0] c1, logic [2:0] c2,
                                          logic [2:0] c3, logic [2:0] c4, logic [2:0] c5,
                                          logic [2:0] c6, logic [2:0] c7);
        return {c7, c6, c5, c4, c3, c2, c1, c0};
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] d, w, w2;
        void'($urandom(32'd8125));

        // R14: pin held high through reset must not count as a rising edge.
        pin_in = 16'h0004;
        tick(3);
        rst_n = 1'b1;
        wr(2'd0, bank0(0, 0, 2, 0, 0, 0, 0, 0));
        tick(5);
        chk("R14 no edge from warm-up", irq_pin, 16'h0000);

        // R1: reset state.
        @(negedge clk); rst_n = 1'b0; pin_in = '0;
        tick(3);
        rst_n = 1'b1;
        tick();
        chk("R1 irq_pin after reset", irq_pin, 16'h0);
        chk("R1 irq_any after reset", irq_any, 1'b0);
        rd(2'd0, d); chk("R1 bank0 reads zero", d, 24'h0);
        rd(2'd1, d); chk("R1 bank1 reads zero", d, 24'h0);
        rd(2'd2, d); chk("R1 status reads zero", d, 24'h0);
        tick(3);

        // R8: layout and readback, address 3 ignored.
        wr(2'd0, 24'hFFFFFF); rd(2'd0, d); chk("R8 bank0 readback", d, 24'hFFFFFF);
        wr(2'd1, 24'h5A5A5A); rd(2'd1, d); chk("R8 bank1 readback", d, 24'h5A5A5A);
        wr(2'd3, 24'h123456); rd(2'd3, d); chk("R8 addr3 reads zero", d, 24'h0);
        rd(2'd0, d); chk("R8 addr3 write leaves bank0", d, 24'hFFFFFF);
        wr(2'd1, 24'h0); wr(2'd2, 24'hFFFF);
        tick();
        rd(2'd2, d); chk("R8 setup status clear", d, 24'h0);

        // Directed styles on pins 0..6.
        w = bank0(0, 1, 2, 3, 4, 5, 7, 0);
        wr(2'd0, w);
        tick(2);
        rd(2'd2, d); chk("R3 level low sets", d, 24'h0002);
        wr(2'd2, 24'hFFFF);
        rd(2'd2, d); chk("R10 level low re-sets after clear", d, 24'h0002);
        pin_in = 16'h0002; tick(4);
        rd(2'd2, d); chk("R9 sticky after level gone", d, 24'h0002);
        wr(2'd2, 24'h0000);
        rd(2'd2, d); chk("R9 zero write leaves bit", d, 24'h0002);
        wr(2'd2, 24'h0002);
        rd(2'd2, d); chk("R9 one write clears bit", d, 24'h0000);

        pin_in = 16'h0077; tick(4);
        chk("R2 R4 R6 R7 rising pattern", irq_pin, 16'h0015);
        chk("R13 irq_any with bits set", irq_any, 1'b1);
        wr(2'd2, 24'h0014);
        rd(2'd2, d); chk("R10 level high re-sets, edges clear", d, 24'h0001);
        pin_in = 16'h0062; tick(4);
        chk("R4 R6 falling pattern", irq_pin, 16'h0011);
        wr(2'd2, 24'hFFFF);
        chk("R9 clear all", irq_pin, 16'h0000);
        chk("R13 irq_any low", irq_any, 1'b0);

        pin_in = 16'h006A; tick(4);
        chk("R5 rise ignored by falling style", irq_pin, 16'h0000);
        pin_in = 16'h0062; tick(4);
        chk("R5 falling sets", irq_pin, 16'h0008);

        // R14: three-edge latency.
        pin_in = 16'h0066;
        tick(2);
        chk("R14 not yet after two edges", irq_pin, 16'h0008);
        tick();
        chk("R14 set after third edge", irq_pin, 16'h000C);

        // R11: detection coincides with a clear.
        pin_in = 16'h0076; tick(4);
        chk("R6 setup bit4", irq_pin, 16'h001C);
        pin_in = 16'h0066;
        tick(2);
        wr(2'd2, 24'h0010);
        chk("R11 edge beats clear", irq_pin & 16'h0010, 16'h0010);
        wr(2'd2, 24'h0010);
        chk("R11 later clear works", irq_pin, 16'h000C);

        // R12: style change clears the pin, others keep their bits.
        pin_in = 16'h0067; tick(4);
        chk("R2 setup bit0", irq_pin, 16'h000D);
        w2 = bank0(2, 1, 2, 3, 4, 5, 7, 0);
        wr(2'd0, w2);
        chk("R12 changed pin cleared", irq_pin, 16'h000C);
        tick(3);
        chk("R12 no stale detection", irq_pin, 16'h000C);
        wr(2'd0, w2);
        chk("R12 same-value rewrite keeps bits", irq_pin, 16'h000C);
        rd(2'd0, d); chk("R8 bank0 holds new word", d, w2);

        // Random traffic against the model.
        for (int n = 0; n < 4000; n++) begin
            for (int b = 0; b < 16; b++) if ($urandom % 8 == 0) pin_in[b] = ~pin_in[b];
            if ($urandom % 6 == 0) begin
                reg_wr = 1'b1; reg_addr = 2'($urandom); reg_wdata = 24'($urandom);
            end else begin
                reg_wr = 1'b0; reg_addr = 2'($urandom);
            end
            #1;
            chk("R13 irq_pin vs model", irq_pin, m_st);
            chk("R13 irq_any vs model", irq_any, |m_st);
            chk("R8 R9 readback vs model", reg_rdata, exp_rd(reg_addr));
            @(negedge clk);
        end
        reg_wr = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule